// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Controller

This block sits on the core side of an external coprocessor. The core hands it an instruction it cannot execute itself, together with the two source register values already read out for that instruction. The controller sends all three to the coprocessor and holds them there. It then waits for the coprocessor to accept and finish the work, or for an acknowledgement timeout to expire. Only non-branching instructions take this path, so the core just advances its program counter once the controller reports completion.

A request enters through a valid/ready handshake. The core raises `req_valid` and holds the instruction and operands steady until it samples `req_ready` high at a clock edge. `req_ready` stays low for the whole time a dispatch is in flight, so the core is held back and one dispatch at most is outstanding. The coprocessor side is a valid/ready pair with two extras. `cp_wait` lets the coprocessor claim more time. `cp_wr` asks for `cp_result` to be written back into the destination register named by the instruction.

Each dispatch ends with exactly one single-cycle outcome pulse. `done_pulse` reports completion and may carry a write-back request. `trap_pulse` reports an illegal-instruction exception, raised because the coprocessor never claimed the instruction.

Top module: `cpx_dispatch`

## Requirements
- R1: `req_ready` is high exactly when no dispatch is in flight. A request accepted at a clock edge raises `cp_valid` in the following cycle.
- R2: While `cp_valid` is high, `cp_insn`, `cp_op_a` and `cp_op_b` carry the accepted instruction and operands and do not change.
- R3: `cp_ready` sampled high in a cycle with `cp_valid` high makes `cp_valid` low and `done_pulse` high in the next cycle, and `done_pulse` lasts one cycle.
- R4: If `cp_wr` is high together with that `cp_ready`, then in the `done_pulse` cycle `wb_en` is high, `wb_idx` equals instruction bits 11:7, and `wb_data` equals the `cp_result` sampled with `cp_ready`.
- R5: A write-back aimed at register index 0 (instruction bits 11:7 all zero) is dropped: `wb_en` stays low, and `done_pulse` still fires.
- R6: If 16 consecutive `cp_valid` cycles pass with neither `cp_ready` nor `cp_wait` high, then in the next cycle `cp_valid` is low and `trap_pulse` is high for one cycle, with `wb_en` low.
- R7: No trap is raised for as long as `cp_wait` is held high; the dispatch stays open until `cp_ready` arrives.
- R8: When `cp_wait` drops without `cp_ready`, a fresh 16-cycle window starts with the first cycle in which `cp_wait` is low.
- R9: `done_pulse` and `trap_pulse` are never high together. `cp_ready` in the sixteenth quiet cycle gives completion, not a trap.
- R10: `cp_ready`, `cp_wait` and `cp_wr` have no effect while `cp_valid` is low: no pulse, no write-back, and no shortening of the next dispatch's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers an instruction for dispatch |
| req_ready | output | 1 | Controller can accept a request |
| req_insn | input | 32 | Instruction word |
| req_op_a | input | 32 | Value of the first source register |
| req_op_b | input | 32 | Value of the second source register |
| cp_valid | output | 1 | Instruction presented to the coprocessor |
| cp_insn | output | 32 | Instruction word to the coprocessor |
| cp_op_a | output | 32 | First operand to the coprocessor |
| cp_op_b | output | 32 | Second operand to the coprocessor |
| cp_ready | input | 1 | Coprocessor has finished the instruction |
| cp_wait | input | 1 | Coprocessor has claimed the instruction and needs time |
| cp_wr | input | 1 | Coprocessor requests result write-back |
| cp_result | input | 32 | Result value for write-back |
| done_pulse | output | 1 | One-cycle completion report |
| trap_pulse | output | 1 | One-cycle illegal-instruction report |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Destination register value |

## Verification
On every cycle, the assertions check these properties: the handshake exclusion, operand stability while valid is high, the one-cycle and mutually exclusive outcome pulses, suppression of write-back to index 0, and absence of any trap while wait is held. A counter in the checker also confirms that a trap comes only after exactly sixteen quiet valid cycles. Only the bench scenarios can show the remaining behaviour. That covers the exact cycle on which each outcome lands for a given ready/wait pattern, the index and data of the write-back, the restarted window after wait drops, and the fact that strobes given while idle leave the next dispatch untouched.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned RD_LSB    = 7;
  localparam int unsigned RD_MSB    = RD_LSB + REG_IDX_W - 1;

  typedef enum logic [0:0] {
    LANE_IDLE = 1'b0,
    LANE_BUSY = 1'b1
  } lane_state_e;

  typedef struct packed {
    logic [XLEN-1:0] insn;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
  } dispatch_word_t;

  typedef struct packed {
    logic                 done;
    logic                 trap;
    logic                 wb_en;
    logic [REG_IDX_W-1:0] wb_idx;
    logic [XLEN-1:0]      wb_data;
  } outcome_t;
endpackage

// File: rtl/cpx_launch.sv
module cpx_launch
  import cpx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           offer,
  input  dispatch_word_t offer_word,
  input  logic           retire,
  output logic           accept_ok,
  output logic           busy,
  output dispatch_word_t held_word
);
  lane_state_e state_q;

  assign accept_ok = (state_q == LANE_IDLE);
  assign busy      = (state_q == LANE_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= LANE_IDLE;
      held_word <= '0;
    end else begin
      unique case (state_q)
        LANE_IDLE: begin
          if (offer) begin
            state_q   <= LANE_BUSY;
            held_word <= offer_word;
          end
        end
        LANE_BUSY: begin
          if (retire) state_q <= LANE_IDLE;
        end
        default: state_q <= LANE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpx_watchdog.sv
module cpx_watchdog #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hold,
  input  logic finish,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] quiet_q;
  logic          quiet_now;

  assign quiet_now = active && !hold && !finish;
  assign expire    = quiet_now && (quiet_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (!quiet_now || expire) begin
      quiet_q <= '0;
    end else begin
      quiet_q <= quiet_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpx_retire.sv
module cpx_retire
  import cpx_pkg::*;
#(
  parameter bit ZERO_REG_FIXED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            fin_ready,
  input  logic            fin_wr,
  input  logic [XLEN-1:0] fin_result,
  input  logic [XLEN-1:0] insn,
  input  logic            expire,
  output outcome_t        outcome
);
  logic [REG_IDX_W-1:0] dest_idx;
  logic                 dest_ok;
  logic                 finish_now;
  logic                 trap_now;

  assign dest_idx   = insn[RD_MSB:RD_LSB];
  assign finish_now = busy && fin_ready;
  assign trap_now   = busy && expire && !fin_ready;

  generate
    if (ZERO_REG_FIXED) begin : g_zero_guard
      assign dest_ok = (dest_idx != '0);
    end else begin : g_no_guard
      assign dest_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outcome <= '0;
    end else begin
      outcome.done    <= finish_now;
      outcome.trap    <= trap_now;
      outcome.wb_en   <= finish_now && fin_wr && dest_ok;
      outcome.wb_idx  <= finish_now ? dest_idx : '0;
      outcome.wb_data <= finish_now ? fin_result : '0;
    end
  end
endmodule

// File: rtl/cpx_dispatch.sv
module cpx_dispatch
  import cpx_pkg::*;
#(
  parameter int unsigned ACK_LIMIT      = 16,
  parameter bit          ZERO_REG_FIXED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [XLEN-1:0]      req_insn,
  input  logic [XLEN-1:0]      req_op_a,
  input  logic [XLEN-1:0]      req_op_b,
  output logic                 cp_valid,
  output logic [XLEN-1:0]      cp_insn,
  output logic [XLEN-1:0]      cp_op_a,
  output logic [XLEN-1:0]      cp_op_b,
  input  logic                 cp_ready,
  input  logic                 cp_wait,
  input  logic                 cp_wr,
  input  logic [XLEN-1:0]      cp_result,
  output logic                 done_pulse,
  output logic                 trap_pulse,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data
);
  dispatch_word_t in_word;
  dispatch_word_t held_word;
  outcome_t       outcome;
  logic           busy;
  logic           accept_ok;
  logic           expire;
  logic           retire;

  assign in_word = '{insn: req_insn, op_a: req_op_a, op_b: req_op_b};
  assign retire  = busy && (cp_ready || expire);

  cpx_launch u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .offer      (req_valid),
    .offer_word (in_word),
    .retire     (retire),
    .accept_ok  (accept_ok),
    .busy       (busy),
    .held_word  (held_word)
  );

  cpx_watchdog #(.LIMIT(ACK_LIMIT)) u_watchdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (busy),
    .hold   (cp_wait),
    .finish (cp_ready),
    .expire (expire)
  );

  cpx_retire #(.ZERO_REG_FIXED(ZERO_REG_FIXED)) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .fin_ready  (cp_ready),
    .fin_wr     (cp_wr),
    .fin_result (cp_result),
    .insn       (held_word.insn),
    .expire     (expire),
    .outcome    (outcome)
  );

  assign req_ready  = accept_ok;
  assign cp_valid   = busy;
  assign cp_insn    = held_word.insn;
  assign cp_op_a    = held_word.op_a;
  assign cp_op_b    = held_word.op_b;
  assign done_pulse = outcome.done;
  assign trap_pulse = outcome.trap;
  assign wb_en      = outcome.wb_en;
  assign wb_idx     = outcome.wb_idx;
  assign wb_data    = outcome.wb_data;
endmodule

// File: rtl/cpx_dispatch_chk.sv
module cpx_dispatch_chk #(
  parameter int unsigned ACK_LIMIT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        cp_valid,
  input logic [31:0] cp_insn,
  input logic [31:0] cp_op_a,
  input logic [31:0] cp_op_b,
  input logic        cp_ready,
  input logic        cp_wait,
  input logic        done_pulse,
  input logic        trap_pulse,
  input logic        wb_en,
  input logic [4:0]  wb_idx
);
  localparam int unsigned QW = $clog2(ACK_LIMIT + 1) + 1;
  logic [QW-1:0] quiet_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) quiet_seen <= '0;
    else if (cp_valid && !cp_wait && !cp_ready) quiet_seen <= quiet_seen + 1'b1;
    else quiet_seen <= '0;
  end

  // R1
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> !req_ready);

  // R2
  operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && $past(cp_valid)) |-> ($stable(cp_insn) && $stable(cp_op_a) && $stable(cp_op_b)));

  // R3
  ready_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_ready) |=> (!cp_valid && done_pulse));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R5
  zero_reg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done_pulse && wb_idx != 5'd0));

  // R6
  trap_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (quiet_seen == QW'(ACK_LIMIT)));

  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_valid && quiet_seen >= QW'(ACK_LIMIT)));

  // R7
  wait_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_wait) |=> !trap_pulse);

  // R9
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && trap_pulse));
endmodule

bind cpx_dispatch cpx_dispatch_chk #(.ACK_LIMIT(ACK_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .cp_valid   (cp_valid),
  .cp_insn    (cp_insn),
  .cp_op_a    (cp_op_a),
  .cp_op_b    (cp_op_b),
  .cp_ready   (cp_ready),
  .cp_wait    (cp_wait),
  .done_pulse (done_pulse),
  .trap_pulse (trap_pulse),
  .wb_en      (wb_en),
  .wb_idx     (wb_idx)
);

// File: tb/cpx_dispatch_tb.sv
module cpx_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_insn = '0, req_op_a = '0, req_op_b = '0;
  logic        cp_valid;
  logic [31:0] cp_insn, cp_op_a, cp_op_b;
  logic        cp_ready = 1'b0, cp_wait = 1'b0, cp_wr = 1'b0;
  logic [31:0] cp_result = '0;
  logic        done_pulse, trap_pulse, wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cpx_dispatch dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_insn(req_insn), .req_op_a(req_op_a), .req_op_b(req_op_b),
    .cp_valid(cp_valid), .cp_insn(cp_insn), .cp_op_a(cp_op_a), .cp_op_b(cp_op_b),
    .cp_ready(cp_ready), .cp_wait(cp_wait), .cp_wr(cp_wr), .cp_result(cp_result),
    .done_pulse(done_pulse), .trap_pulse(trap_pulse),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  rdy_at;   // valid-cycle index of ready, 255 = never
    logic [7:0]  wt_from;  // wait high on indices [wt_from, wt_to)
    logic [7:0]  wt_to;
    logic        wr;
    logic [31:0] res;
    logic [7:0]  exp_len;  // valid cycles expected
    logic        exp_trap;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{32'h0A31_82AB, 32'h1111_0001, 32'h2222_0001, 8'd0,   8'd0, 8'd0,  1'b1, 32'hCAFE_0001, 8'd1,  1'b0},
    '{32'h0000_0F0B, 32'h1111_0002, 32'h2222_0002, 8'd3,   8'd0, 8'd0,  1'b0, 32'hCAFE_0002, 8'd4,  1'b0},
    '{32'h0000_0F8B, 32'h1111_0003, 32'h2222_0003, 8'd15,  8'd0, 8'd0,  1'b1, 32'hCAFE_0003, 8'd16, 1'b0},
    '{32'h0000_0A8B, 32'h1111_0004, 32'h2222_0004, 8'd255, 8'd0, 8'd0,  1'b1, 32'hCAFE_0004, 8'd16, 1'b1},
    '{32'h0000_010B, 32'h1111_0005, 32'h2222_0005, 8'd20,  8'd0, 8'd20, 1'b1, 32'hCAFE_0005, 8'd21, 1'b0},
    '{32'h0000_018B, 32'h1111_0006, 32'h2222_0006, 8'd255, 8'd2, 8'd6,  1'b0, 32'hCAFE_0006, 8'd22, 1'b1},
    '{32'h0000_007B, 32'h1111_0007, 32'h2222_0007, 8'd2,   8'd0, 8'd0,  1'b1, 32'hCAFE_0007, 8'd3,  1'b0},
    '{32'h0000_020B, 32'h1111_0008, 32'h2222_0008, 8'd15,  8'd15,8'd16, 1'b1, 32'hCAFE_0008, 8'd16, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int k;
    logic [4:0] rd;
    rd = v.insn[11:7];
    @(negedge clk);
    req_valid = 1'b1; req_insn = v.insn; req_op_a = v.a; req_op_b = v.b;
    check(req_ready == 1'b1, "R1", {tag, " ready when idle"}, {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    #1 req_valid = 1'b0; req_insn = '0; req_op_a = '0; req_op_b = '0;
    k = 0;
    forever begin
      @(negedge clk);
      if (!cp_valid) break;
      if (cp_insn != v.insn || cp_op_a != v.a || cp_op_b != v.b)
        check(1'b0, "R2", {tag, " operand hold"}, cp_op_a, v.a);
      if (req_ready) check(1'b0, "R1", {tag, " ready while busy"}, 32'd1, 32'd0);
      cp_ready  = (k == int'(v.rdy_at));
      cp_wait   = (k >= int'(v.wt_from)) && (k < int'(v.wt_to));
      cp_wr     = v.wr;
      cp_result = v.res;
      k++;
      if (k > 200) break;
    end
    cp_ready = 1'b0; cp_wait = 1'b0; cp_wr = 1'b0; cp_result = '0;
    check(k == int'(v.exp_len), v.exp_trap ? "R6" : "R3", {tag, " valid length"}, k, v.exp_len);
    check(trap_pulse == v.exp_trap && done_pulse == !v.exp_trap, "R9",
          {tag, " outcome kind"}, {30'd0, done_pulse, trap_pulse}, {30'd0, !v.exp_trap, v.exp_trap});
    if (!v.exp_trap && v.wr && rd != 5'd0) begin
      check(wb_en && wb_idx == rd && wb_data == v.res, "R4", {tag, " write-back"}, wb_data, v.res);
      check(wb_idx == rd, "R4", {tag, " write index"}, wb_idx, rd);
    end else begin
      check(wb_en == 1'b0, (v.wr && rd == 5'd0) ? "R5" : "R6", {tag, " no write"},
            {31'd0, wb_en}, 32'd0);
    end
    @(negedge clk);
    check(!done_pulse && !trap_pulse, "R3", {tag, " pulse one cycle"},
          {30'd0, done_pulse, trap_pulse}, 32'd0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cp_valid && !done_pulse && !trap_pulse && !wb_en, "R1", "reset outputs",
          {28'd0, cp_valid, done_pulse, trap_pulse, wb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], $sformatf("vec%0d", i));

    // R10: strobes while idle have no effect
    cp_ready = 1'b1; cp_wait = 1'b1; cp_wr = 1'b1; cp_result = 32'hDEAD_BEEF;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(!cp_valid && !done_pulse && !trap_pulse && !wb_en, "R10", "idle strobes ignored",
            {28'd0, cp_valid, done_pulse, trap_pulse, wb_en}, 32'd0);
    end
    cp_ready = 1'b0; cp_wait = 1'b0; cp_wr = 1'b0; cp_result = '0;
    // R10: the following dispatch still gets a full window
    run_vec('{32'h0000_028B, 32'h3, 32'h4, 8'd255, 8'd0, 8'd0, 1'b0, 32'h0, 8'd16, 1'b1}, "R10 post-idle");
    // R7: long wait held, then ready
    run_vec('{32'h0000_030B, 32'h5, 32'h6, 8'd60, 8'd0, 8'd60, 1'b1, 32'h77, 8'd61, 1'b0}, "R7 long wait");
    // R8: wait pulse late in window restarts count
    run_vec('{32'h0000_038B, 32'h7, 32'h8, 8'd255, 8'd14, 8'd15, 1'b0, 32'h0, 8'd31, 1'b1}, "R8 restart");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule